// File: doc/BRIEF.md
# Talker Byte Readout Engine

This block moves a finished capture out of byte-wide memory and onto an 8-bit parallel instrument bus. It becomes active only when two things are true: the card holds talker status, and the controller has issued a go command. It then walks the memory from address zero upward. For each byte it sets the address and read enable, and drives the memory byte onto the data lines. It also acts as the source in the three-wire handshake. The data-valid line is open-collector, so the block only ever pulls it low or lets it go.

The two listener lines are shown here as plain active-high flags:

- `lsn_not_ready` is high while any listener cannot yet take a byte.
- `lsn_not_accepted` is high while any listener has not yet taken the current byte.

The sequence for each byte is:

1. Wait for `lsn_not_ready` to be released and for a settling time to elapse.
2. Pull data-valid.
3. Hold it until `lsn_not_accepted` is released.
4. Release data-valid and step the address.

Once the final byte of the fixed-length record has been taken, the block raises a one-cycle untalk pulse. That pulse clears the card's talker latch, which frees the data lines, and the block returns to its ready state.

If talker status is withdrawn during a record, the block parks. It lets go of data-valid and keeps its address. When talker status is assigned again, it resends the byte that was interrupted and then carries on.

Top module: `talker_readout`

## Requirements
- R1: After reset the block is ready (`rdy`=1), with `dav_pull`=0, `untalk_pulse`=0, `mem_oe`=0, `bus_data_oe`=0 and `mem_addr`=0.
- R2: A transfer starts only on a one-cycle `xfer_go` while `rdy`=1 and `talk_en_n`=0. The start clears the address to 0. `xfer_go` is ignored when `talk_en_n`=1 and while a transfer is in progress.
- R3: `bus_data_oe` is 1 only while `talk_en_n`=0 and a transfer is in progress. Whenever `bus_data_oe` is 0, `bus_data` is 0.
- R4: Bytes go out in ascending memory order starting at address 0. A sample stored high byte at the even address is therefore sent high byte first. While `dav_pull`=1, `bus_data` equals `mem_rdata` for the current `mem_addr`.
- R5: `dav_pull` is not raised while `lsn_not_ready`=1. It is raised no sooner than SETTLE_CYC+1 cycles after the address was last set.
- R6: Once raised, `dav_pull` stays 1 while `lsn_not_accepted`=1. The first edge that sees `lsn_not_accepted`=0 drops `dav_pull` and advances `mem_addr` by one.
- R7: When `talk_en_n` goes to 1 during a transfer, `dav_pull` is 0 from the next cycle and `mem_addr` is held. When `talk_en_n` returns to 0, the same byte is sent again.
- R8: If `talk_en_n`=1 at the same edge that would accept the byte, the loss of talker status wins. The address does not advance and no untalk pulse is issued.
- R9: After the byte at address REC_BYTES-1 is accepted, `untalk_pulse` is 1 for exactly one cycle. The block is then ready again with `mem_oe`=0.
- R10: A record is REC_BYTES bytes (default 16384). After the last byte the address wraps to 0, so a new `xfer_go` sends the record again from address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| talk_en_n | input | 1 | Talker status from the talker latch, active low |
| xfer_go | input | 1 | One-cycle command from the controller to send the record |
| lsn_not_ready | input | 1 | 1 while some listener is not ready for a byte |
| lsn_not_accepted | input | 1 | 1 while some listener has not accepted the byte |
| mem_rdata | input | 8 | Byte read from capture memory at `mem_addr` |
| mem_addr | output | $clog2(REC_BYTES) | Capture memory read address |
| mem_oe | output | 1 | Memory output enable, high while a transfer is in progress |
| bus_data | output | 8 | Byte driven onto the instrument bus data lines |
| bus_data_oe | output | 1 | Enable for the bus data drivers |
| dav_pull | output | 1 | 1 pulls the open-collector data-valid line low, 0 releases it |
| untalk_pulse | output | 1 | One-cycle pulse that clears the card's own talker status |
| rdy | output | 1 | Block idle and ready for a new record |

## Verification
Two events can land on the same clock edge: the listener accepting the final byte, and talker status being withdrawn. Whichever one wins decides whether the record completes.

The bench provokes this directly. With data-valid held on the last byte, it releases `lsn_not_accepted` and raises `talk_en_n` at the same negative edge. It then checks three things:

- no untalk pulse is issued;
- the address stays on the last byte;
- `dav_pull` is released.

Next it reassigns talker status and expects the same last byte to be sent again, followed by exactly one untalk pulse. The same check of a held address and a resent byte is also applied to a withdrawal in the middle of the record.

// File: rtl/talker_pkg.sv
package talker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETTLE = 3'd1,
        ST_VALID  = 3'd2,
        ST_HOLD   = 3'd3,
        ST_UNTALK = 3'd4
    } tk_state_e;

    typedef struct packed {
        tk_state_e state;
    } tk_regs_t;

endpackage

// File: rtl/talker_settle.sv
module talker_settle #(
    parameter int SETTLE_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    generate
        if (SETTLE_CYC == 0) begin : g_none
            assign done = run;
        end else begin : g_count
            localparam int CW = $clog2(SETTLE_CYC + 1);
            localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (!run) begin
                    cnt_d = '0;
                end else if (cnt_q != LIMIT) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign done = run && (cnt_q == LIMIT);

            // R5
            settle_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> !done);
        end
    endgenerate

endmodule

// File: rtl/talker_addr.sv
module talker_addr #(
    parameter int REC_BYTES = 16384,
    parameter int ADDR_W    = $clog2(REC_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(REC_BYTES - 1);

    logic [ADDR_W-1:0] addr_d, addr_q, addr_inc;

    generate
        if (REC_BYTES == (1 << ADDR_W)) begin : g_pow2
            assign addr_inc = addr_q + 1'b1;
        end else begin : g_mod
            assign addr_inc = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;
        end
    endgenerate

    always_comb begin
        addr_d = addr_q;
        if (clear) begin
            addr_d = '0;
        end else if (step) begin
            addr_d = addr_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr = addr_q;
    assign last = (addr_q == LAST_ADDR);

    // R10
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && last) |=> (addr == '0));

endmodule

// File: rtl/talker_readout.sv
module talker_readout #(
    parameter int REC_BYTES  = 16384,
    parameter int SETTLE_CYC = 2,
    parameter int DW         = 8,
    parameter int ADDR_W     = $clog2(REC_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              talk_en_n,
    input  logic              xfer_go,
    input  logic              lsn_not_ready,
    input  logic              lsn_not_accepted,
    input  logic [DW-1:0]     mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_oe,
    output logic [DW-1:0]     bus_data,
    output logic              bus_data_oe,
    output logic              dav_pull,
    output logic              untalk_pulse,
    output logic              rdy
);

    import talker_pkg::*;

    tk_regs_t r_d, r_q;

    logic talker;
    logic settle_done;
    logic addr_last;
    logic addr_clear;
    logic addr_step;

    assign talker = !talk_en_n;

    talker_settle #(
        .SETTLE_CYC (SETTLE_CYC)
    ) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_SETTLE),
        .done  (settle_done)
    );

    talker_addr #(
        .REC_BYTES (REC_BYTES),
        .ADDR_W    (ADDR_W)
    ) u_addr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (addr_clear),
        .step  (addr_step),
        .addr  (mem_addr),
        .last  (addr_last)
    );

    always_comb begin
        r_d        = r_q;
        addr_clear = 1'b0;
        addr_step  = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (xfer_go && talker) begin
                    r_d.state  = ST_SETTLE;
                    addr_clear = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (!talker) begin
                    r_d.state = ST_HOLD;
                end else if (settle_done && !lsn_not_ready) begin
                    r_d.state = ST_VALID;
                end
            end
            ST_VALID: begin
                if (!talker) begin
                    r_d.state = ST_HOLD;
                end else if (!lsn_not_accepted) begin
                    addr_step = 1'b1;
                    r_d.state = addr_last ? ST_UNTALK : ST_SETTLE;
                end
            end
            ST_HOLD: begin
                if (talker) begin
                    r_d.state = ST_SETTLE;
                end
            end
            ST_UNTALK: begin
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign rdy          = (r_q.state == ST_IDLE);
    assign mem_oe       = (r_q.state != ST_IDLE);
    assign dav_pull     = (r_q.state == ST_VALID);
    assign untalk_pulse = (r_q.state == ST_UNTALK);
    assign bus_data_oe  = talker && mem_oe;
    assign bus_data     = bus_data_oe ? mem_rdata : '0;

    // R7
    dav_drop_on_untalk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        talk_en_n |=> !dav_pull);

    // R5
    dav_wait_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETTLE && lsn_not_ready) |=> !dav_pull);

    // R5
    dav_wait_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SETTLE && !settle_done) |=> !dav_pull);

    // R6
    dav_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dav_pull && lsn_not_accepted && !talk_en_n) |=> dav_pull);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy && !(dav_pull && !lsn_not_accepted && !talk_en_n)) |=> $stable(mem_addr));

    // R9
    untalk_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        untalk_pulse |=> (!untalk_pulse && rdy));

    // R3
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> (!talk_en_n && !rdy));

endmodule

// File: tb/talker_readout_bench.sv
module talker_readout_bench;

    localparam int REC    = 24;
    localparam int SETTLE = 2;
    localparam int AW     = $clog2(REC);

    // listener timing per byte: high nibble = not-ready hold, low nibble = not-accepted hold
    localparam logic [7:0] LSN_TIMING [8] = '{
        8'h12, 8'h31, 8'h13, 8'h54, 8'h21, 8'h15, 8'h41, 8'h22
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          talk_en_n = 1'b1;
    logic          xfer_go = 1'b0;
    logic          lsn_not_ready = 1'b1;
    logic          lsn_not_accepted = 1'b1;
    logic [7:0]    mem_rdata;
    logic [AW-1:0] mem_addr;
    logic          mem_oe, bus_data_oe, dav_pull, untalk_pulse, rdy;
    logic [7:0]    bus_data;

    int n_total = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] mem_byte(input int a);
        return 8'(a * 37 + 5) ^ 8'(a >> 3);
    endfunction

    assign mem_rdata = mem_byte(int'(mem_addr));

    talker_readout #(
        .REC_BYTES  (REC),
        .SETTLE_CYC (SETTLE)
    ) u_talker_readout (
        .clk              (clk),
        .rst_n            (rst_n),
        .talk_en_n        (talk_en_n),
        .xfer_go          (xfer_go),
        .lsn_not_ready    (lsn_not_ready),
        .lsn_not_accepted (lsn_not_accepted),
        .mem_rdata        (mem_rdata),
        .mem_addr         (mem_addr),
        .mem_oe           (mem_oe),
        .bus_data         (bus_data),
        .bus_data_oe      (bus_data_oe),
        .dav_pull         (dav_pull),
        .untalk_pulse     (untalk_pulse),
        .rdy              (rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_go();
        @(negedge clk) xfer_go = 1'b1;
        @(negedge clk) xfer_go = 1'b0;
    endtask

    // listener holds not-ready, releases it, waits for data-valid, checks the byte
    task automatic start_byte(input int idx, input int nh);
        bit seen_early;
        bit got;
        seen_early = 1'b0;
        got = 1'b0;
        lsn_not_ready = 1'b1;
        lsn_not_accepted = 1'b1;
        for (int i = 0; i < nh; i++) begin
            @(negedge clk);
            if (dav_pull) seen_early = 1'b1;
        end
        chk(!seen_early, "R5 no data-valid while not ready", int'(seen_early), 0);
        lsn_not_ready = 1'b0;
        for (int i = 0; i < 64 && !got; i++) begin
            @(negedge clk);
            if (dav_pull) got = 1'b1;
        end
        chk(got, "R5 data-valid raised after ready", int'(got), 1);
        chk(int'(mem_addr) == idx, "R4 address order", int'(mem_addr), idx);
        chk(bus_data == mem_byte(idx) && bus_data_oe, "R4 byte on bus",
            int'(bus_data), int'(mem_byte(idx)));
        lsn_not_ready = 1'b1;
    endtask

    // listener holds not-accepted, then releases it and waits for data-valid release
    task automatic finish_byte(input int idx, input int dh);
        bit dropped_early;
        bit released;
        dropped_early = 1'b0;
        released = 1'b0;
        for (int i = 0; i < dh; i++) begin
            @(negedge clk);
            if (!dav_pull) dropped_early = 1'b1;
        end
        chk(!dropped_early, "R6 data-valid held until accepted", int'(dropped_early), 0);
        lsn_not_accepted = 1'b0;
        for (int i = 0; i < 16 && !released; i++) begin
            @(negedge clk);
            if (!dav_pull) released = 1'b1;
        end
        chk(released, "R6 data-valid released on accept", int'(released), 1);
        if (idx != REC - 1) begin
            chk(int'(mem_addr) == idx + 1, "R6 address advanced", int'(mem_addr), idx + 1);
        end else begin
            chk(mem_addr == '0, "R10 address wrapped", int'(mem_addr), 0);
        end
        lsn_not_accepted = 1'b1;
    endtask

    task automatic send_byte(input int idx);
        logic [7:0] t;
        t = LSN_TIMING[idx % 8];
        start_byte(idx, int'(t[7:4]));
        finish_byte(idx, int'(t[3:0]));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rdy && !dav_pull && !untalk_pulse && !mem_oe && !bus_data_oe && mem_addr == '0,
            "R1 reset state", {rdy, dav_pull, untalk_pulse, mem_oe, bus_data_oe}, 5'b10000);

        // R2: go without talker status is ignored
        pulse_go();
        repeat (4) @(negedge clk);
        chk(rdy && !mem_oe, "R2 go ignored without talker", int'(rdy), 1);

        // R2: talker but no command - waits
        talk_en_n = 1'b0;
        repeat (8) @(negedge clk);
        chk(rdy && !dav_pull && !bus_data_oe, "R3 idle talker drives nothing",
            {rdy, dav_pull, bus_data_oe}, 3'b100);

        pulse_go();
        chk(!rdy && mem_oe && bus_data_oe && mem_addr == '0, "R2 transfer started",
            {rdy, mem_oe, bus_data_oe}, 3'b011);

        // main stream, table-driven listener timing
        for (int k = 0; k < 10; k++) send_byte(k);

        // R7: withdraw talker status while data-valid is up on byte 10
        start_byte(10, 2);
        @(negedge clk) talk_en_n = 1'b1;
        @(negedge clk);
        chk(!dav_pull, "R7 data-valid dropped on talk loss", int'(dav_pull), 0);
        chk(!bus_data_oe && bus_data == '0, "R3 drivers off without talker",
            int'(bus_data_oe), 0);
        repeat (5) @(negedge clk);
        chk(int'(mem_addr) == 10 && !dav_pull && !rdy, "R7 address held while parked",
            int'(mem_addr), 10);
        talk_en_n = 1'b0;
        send_byte(10);

        for (int k = 11; k < REC - 1; k++) send_byte(k);

        // R8: acceptance and talk loss on the same edge for the last byte
        start_byte(REC - 1, 1);
        @(negedge clk);
        lsn_not_accepted = 1'b0;
        talk_en_n = 1'b1;
        @(negedge clk);
        chk(!dav_pull && !untalk_pulse, "R8 talk loss wins, no untalk",
            {dav_pull, untalk_pulse}, 0);
        chk(int'(mem_addr) == REC - 1 && !rdy, "R8 address not advanced",
            int'(mem_addr), REC - 1);
        lsn_not_accepted = 1'b1;
        talk_en_n = 1'b0;
        send_byte(REC - 1);
        chk(untalk_pulse, "R9 untalk after last byte", int'(untalk_pulse), 1);
        @(negedge clk);
        chk(!untalk_pulse && rdy && !mem_oe, "R9 single pulse then ready",
            {untalk_pulse, rdy, mem_oe}, 3'b010);
        talk_en_n = 1'b1;
        @(negedge clk);
        chk(!bus_data_oe, "R3 drivers off after untalk", int'(bus_data_oe), 0);

        // R10 / R2: second record restarts at 0, go while busy ignored
        talk_en_n = 1'b0;
        pulse_go();
        chk(mem_addr == '0 && !rdy, "R10 new record starts at 0", int'(mem_addr), 0);
        send_byte(0);
        send_byte(1);
        pulse_go();
        send_byte(2);
        chk(int'(mem_addr) == 3, "R2 go ignored while busy", int'(mem_addr), 3);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule